// File: doc/BRIEF.md
# Packet FIFO with Direction-Aware Threshold Interrupt

This block is a 32-entry byte queue placed between a host register port and a radio datapath. In transmit direction the host fills the queue and the radio drains it. In receive direction the radio fills it and the host drains it. Both sides may be active during one radio operation, so any number of bytes can stream through while the occupancy stays at or below the depth. The host accesses the queue through one data location: each accepted write strobe pushes a byte and each read strobe pops one. A burst is simply a run of consecutive strobes.

A programmable 5-bit level drives a single interrupt line whose active level is selectable. In receive direction the line means "nearly full". In transmit direction it means "nearly empty", and it only counts once the queue has been filled past the trigger point at least once. A one-cycle terminate pulse tells the radio controller to go idle when the queue fills in receive or drains in transmit. Changing direction, or a flush strobe, empties the queue and clears all status. Out-of-range host accesses are absorbed and reported through sticky flags.

Top module: `pkt_fifo_irq`

## Requirements
- R1: The queue holds up to 32 bytes and returns them in the order they were accepted. `fill_count` shows the number of stored bytes after each clock edge.
- R2: With `mode_tx`=1 the writer is `host_wr` and the reader is `radio_pop`. With `mode_tx`=0 the writer is `radio_push` and the reader is `host_rd`. Strobes from the inactive side leave `fill_count` unchanged.
- R3: A byte read out appears on `rd_data` in the cycle after its pop strobe. A pop strobe on an empty queue yields 0x00. A `host_rd` on an empty queue in receive direction sets `unf_flag`.
- R4: A push to a full queue is dropped. A `host_wr` to a full queue in transmit direction sets `ovf_flag`. Both flags stay set until a flush or a direction change.
- R5: After reset the threshold is 30 and the interrupt polarity is active-high (`cfg_pol`=0). A `cfg_wr` strobe loads `cfg_thresh` and `cfg_pol`.
- R6: In receive direction the interrupt is active while `fill_count` >= threshold and inactive while it is below.
- R7: In transmit direction an arming flag sets once `fill_count` exceeds 32 minus threshold. While armed, the interrupt is active when `fill_count` <= 32 minus threshold and inactive above it (default: active at 2 or fewer bytes).
- R8: With `cfg_pol`=1 the `irq` output is the inverse of the active-high level.
- R9: `terminate` pulses for one cycle in two cases: when a transmit pop leaves the queue empty, and when a receive push leaves it holding 32 bytes.
- R10: A `flush` strobe or a change of `mode_tx` clears the count, the pointers, the arming flag and both sticky flags in one cycle. Strobes in that cycle are ignored.
- R11: A push and a pop in the same cycle, neither blocked, leave `fill_count` unchanged. This lets more than 32 bytes pass through in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | 1 = transmit direction, 0 = receive direction |
| flush | input | 1 | Empty the queue and clear status |
| cfg_wr | input | 1 | Load threshold and polarity |
| cfg_thresh | input | 5 | New threshold value |
| cfg_pol | input | 1 | New polarity, 1 = active-low interrupt |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | 8 | Host push byte |
| host_rd | input | 1 | Host pop strobe |
| radio_push | input | 1 | Radio push strobe |
| radio_wdata | input | 8 | Radio push byte |
| radio_pop | input | 1 | Radio pop strobe |
| rd_data | output | 8 | Byte from the last pop strobe |
| fill_count | output | 6 | Number of stored bytes |
| irq | output | 1 | Threshold interrupt |
| terminate | output | 1 | One-cycle end-of-operation request |
| ovf_flag | output | 1 | Sticky push-to-full flag |
| unf_flag | output | 1 | Sticky pop-from-empty flag |

## Verification
The queue is driven in five patterns:
- A receive fill past the default threshold up to full. This separates the "reaches threshold" edge from the "full" terminate edge.
- A transmit fill followed by a drain. This shows that the nearly-empty line stays quiet during the early low counts and fires only on the way down.
- A rewrite of threshold and polarity, then a receive fill and drain across the new trigger. This tells level inversion apart from a trigger off by one.
- Simultaneous push and pop in transmit over more than 32 bytes. This separates correct wrap-around from stale or repeated data.
- Strobes from the inactive side, at the boundaries, and across a direction change. These show that blocked or ignored strobes alter neither count nor data.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/pfq_mem.sv
// Simple dual-port byte storage with registered read, suitable for block RAM.
module pfq_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pfq_ctrl.sv
// Pointer and occupancy control; blocks pushes at full and pops at empty.
module pfq_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   count,
  output logic [AW:0]   count_nxt,
  output logic          full,
  output logic          empty
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [AW-1:0] wptr, rptr;

  assign full    = (count == FULL_LVL);
  assign empty   = (count == '0);
  assign push_ok = push && !clear && !full;
  assign pop_ok  = pop && !clear && !empty;
  assign waddr   = wptr;
  assign raddr   = rptr;

  always_comb begin
    if (clear) count_nxt = '0;
    else       count_nxt = count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/pfq_irq.sv
// Direction-dependent threshold interrupt and terminate request.
module pfq_irq #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          is_tx,
  input  logic [AW-1:0] thr,
  input  logic          pol,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [AW:0]   count_nxt,
  output logic          irq,
  output logic          terminate
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic          armed, armed_nxt, lvl, term_nxt;
  logic [AW:0]   tx_limit;

  assign tx_limit = FULL_LVL - {1'b0, thr};

  always_comb begin
    if (clear) armed_nxt = 1'b0;
    else       armed_nxt = armed || (is_tx && (count_nxt > tx_limit));
    if (is_tx) lvl = armed_nxt && (count_nxt <= tx_limit);
    else       lvl = (count_nxt >= {1'b0, thr});
    if (clear)      term_nxt = 1'b0;
    else if (is_tx) term_nxt = pop_ok && (count_nxt == '0);
    else            term_nxt = push_ok && (count_nxt == FULL_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      irq       <= 1'b0;
      terminate <= 1'b0;
    end else begin
      armed     <= armed_nxt;
      irq       <= lvl ^ pol;
      terminate <= term_nxt;
    end
  end
endmodule

// File: rtl/pkt_fifo_irq.sv
module pkt_fifo_irq #(
  parameter int DW      = 8,
  parameter int DEPTH   = 32,
  parameter int THR_RST = 30,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_tx,
  input  logic          flush,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_thresh,
  input  logic          cfg_pol,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          radio_push,
  input  logic [DW-1:0] radio_wdata,
  input  logic          radio_pop,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   fill_count,
  output logic          irq,
  output logic          terminate,
  output logic          ovf_flag,
  output logic          unf_flag
);
  import pkt_fifo_pkg::*;

  dir_e          dir, mode_q;
  logic [AW-1:0] thr_q;
  logic          pol_q;
  logic          clear, push_req, pop_req, push_ok, pop_ok, full, empty;
  logic [DW-1:0] push_data, mem_q;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   count_nxt;
  logic          rd_zero;

  assign dir       = dir_e'(mode_tx);
  assign clear     = flush || (dir != mode_q);
  assign push_req  = (dir == DIR_TX) ? host_wr    : radio_push;
  assign push_data = (dir == DIR_TX) ? host_wdata : radio_wdata;
  assign pop_req   = (dir == DIR_TX) ? radio_pop  : host_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= DIR_RX;
      thr_q    <= AW'(THR_RST);
      pol_q    <= 1'b0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rd_zero  <= 1'b1;
    end else begin
      mode_q <= dir;
      if (cfg_wr) begin
        thr_q <= cfg_thresh;
        pol_q <= cfg_pol;
      end
      if (clear) begin
        ovf_flag <= 1'b0;
        unf_flag <= 1'b0;
      end else begin
        if ((dir == DIR_TX) && host_wr && full)  ovf_flag <= 1'b1;
        if ((dir == DIR_RX) && host_rd && empty) unf_flag <= 1'b1;
        if (pop_req) rd_zero <= !pop_ok;
      end
    end
  end

  assign rd_data = rd_zero ? '0 : mem_q;

  pfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .push      (push_req),
    .pop       (pop_req),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .waddr     (waddr),
    .raddr     (raddr),
    .count     (fill_count),
    .count_nxt (count_nxt),
    .full      (full),
    .empty     (empty)
  );

  pfq_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (push_ok),
    .waddr (waddr),
    .wdata (push_data),
    .re    (pop_ok),
    .raddr (raddr),
    .rdata (mem_q)
  );

  pfq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .is_tx     (dir == DIR_TX),
    .thr       (thr_q),
    .pol       (pol_q),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .count_nxt (count_nxt),
    .irq       (irq),
    .terminate (terminate)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_tx,
  input logic          mode_q,
  input logic          flush,
  input logic          host_wr,
  input logic          radio_pop,
  input logic [AW-1:0] thr_q,
  input logic          pol_q,
  input logic [AW:0]   fill_count,
  input logic          irq,
  input logic          terminate,
  input logic          ovf_flag,
  input logic          unf_flag
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  AST_CNT_MAX: assert property (@(posedge clk) disable iff (rst)
    fill_count <= FULL_LVL); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (mode_tx && mode_q && !flush && host_wr && !radio_pop && fill_count == FULL_LVL)
    |=> (fill_count == FULL_LVL && ovf_flag)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flush && (mode_tx == mode_q)) |=> ovf_flag); // R4

  AST_RX_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_tx) |-> (irq == (({1'b0, $past(thr_q)} <= fill_count) ^ $past(pol_q)))); // R6

  AST_TERM_EDGE: assert property (@(posedge clk) disable iff (rst)
    terminate |-> (fill_count == ($past(mode_tx) ? '0 : FULL_LVL))); // R9

  AST_TERM_PULSE: assert property (@(posedge clk) disable iff (rst)
    terminate |=> !terminate); // R9

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill_count == '0 && !ovf_flag && !unf_flag)); // R10
endmodule

bind pkt_fifo_irq pfq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_tx    (mode_tx),
  .mode_q     (mode_q),
  .flush      (flush),
  .host_wr    (host_wr),
  .radio_pop  (radio_pop),
  .thr_q      (thr_q),
  .pol_q      (pol_q),
  .fill_count (fill_count),
  .irq        (irq),
  .terminate  (terminate),
  .ovf_flag   (ovf_flag),
  .unf_flag   (unf_flag)
);

// File: tb/tb_pkt_fifo_irq.sv
`timescale 1ns/1ps
module tb_pkt_fifo_irq;
  logic       clk = 0, rst = 1;
  logic       mode_tx = 0, flush = 0, cfg_wr = 0, cfg_pol = 0;
  logic [4:0] cfg_thresh = 0;
  logic       host_wr = 0, host_rd = 0, radio_push = 0, radio_pop = 0;
  logic [7:0] host_wdata = 0, radio_wdata = 0;
  logic [7:0] rd_data;
  logic [5:0] fill_count;
  logic       irq, terminate, ovf_flag, unf_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pkt_fifo_irq dut (.*);

  // scoreboard model state
  logic [7:0] sb_q[$];
  bit  m_mode = 0, m_armed = 0, m_ovf = 0, m_unf = 0, m_pol = 0;
  int  m_thr = 30;

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: updates the scoreboard from the strobes and compares after the edge
  always @(posedge clk) begin
    if (rst) begin
      sb_q.delete(); m_mode = 0; m_armed = 0; m_ovf = 0; m_unf = 0; m_pol = 0; m_thr = 30;
    end else begin
      bit tx, clr, pw, pr, push_ok, pop_ok, rd_chk, lvl, e_irq, e_term;
      logic [7:0] wd, rd_exp;
      int cnt, nc, lim;
      tx = mode_tx; clr = flush || (mode_tx != m_mode);
      cnt = sb_q.size();
      pw = tx ? host_wr : radio_push; wd = tx ? host_wdata : radio_wdata;
      pr = tx ? radio_pop : host_rd;
      push_ok = pw && !clr && cnt != 32;
      pop_ok  = pr && !clr && cnt != 0;
      rd_chk = 0; rd_exp = 0;
      if (clr) begin
        sb_q.delete(); m_ovf = 0; m_unf = 0;
      end else begin
        if (pr) begin rd_chk = 1; rd_exp = pop_ok ? sb_q.pop_front() : 8'h00; end
        if (tx && host_wr && cnt == 32) m_ovf = 1;
        if (!tx && host_rd && cnt == 0) m_unf = 1;
      end
      if (push_ok) sb_q.push_back(wd);
      nc = sb_q.size(); lim = 32 - m_thr;
      m_armed = clr ? 0 : (m_armed || (tx && nc > lim));
      lvl = tx ? (m_armed && nc <= lim) : (nc >= m_thr);
      e_irq = lvl ^ m_pol;
      e_term = !clr && (tx ? (pop_ok && nc == 0) : (push_ok && nc == 32));
      if (cfg_wr) begin m_thr = cfg_thresh; m_pol = cfg_pol; end
      m_mode = mode_tx;
      #2;
      check("R1", fill_count, nc, "fill_count");
      check(m_pol ? "R8" : (tx ? "R7" : "R6"), irq, e_irq, "irq");
      check("R9", terminate, e_term, "terminate");
      check("R4", ovf_flag, m_ovf, "ovf_flag");
      check("R3", unf_flag, m_unf, "unf_flag");
      if (rd_chk) check("R3", rd_data, rd_exp, "rd_data");
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic rpush(input logic [7:0] b);
    radio_push = 1; radio_wdata = b; step(); radio_push = 0;
  endtask
  task automatic hpush(input logic [7:0] b);
    host_wr = 1; host_wdata = b; step(); host_wr = 0;
  endtask
  task automatic hpop(); host_rd = 1; step(); host_rd = 0; endtask
  task automatic rpop(); radio_pop = 1; step(); radio_pop = 0; endtask
  task automatic do_flush(); flush = 1; step(); flush = 0; endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R5 reset state
    check("R5", fill_count, 0, "reset fill_count");
    check("R5", irq, 0, "reset irq");
    check("R5", {ovf_flag, unf_flag, terminate}, 0, "reset flags");

    // receive fill: R5 default threshold 30, R6, R9 full
    for (int i = 0; i < 29; i++) rpush(8'(i + 1));
    check("R5", irq, 0, "irq below default threshold");
    rpush(8'd30);
    check("R6", irq, 1, "irq at threshold 30");
    rpush(8'd31);
    rpush(8'd32);
    check("R9", terminate, 1, "terminate at full rx");
    rpush(8'hEE);
    check("R4", fill_count, 32, "push to full dropped");
    host_wr = 1; host_wdata = 8'h55; step(); host_wr = 0;
    check("R2", fill_count, 32, "host_wr ignored in rx");
    radio_pop = 1; step(); radio_pop = 0;
    check("R2", fill_count, 32, "radio_pop ignored in rx");
    for (int i = 0; i < 3; i++) hpop();
    check("R6", irq, 0, "irq released below threshold");
    for (int i = 0; i < 29; i++) hpop();
    hpop();
    step();
    check("R3", rd_data, 0, "pop empty returns zero");
    check("R3", unf_flag, 1, "underflow set");
    do_flush();
    check("R10", unf_flag, 0, "flush clears underflow");

    // transmit: R7 arming and nearly-empty
    mode_tx = 1; step();
    check("R10", fill_count, 0, "mode change clears");
    hpush(8'hA0); hpush(8'hA1);
    check("R7", irq, 0, "no irq before arming");
    for (int i = 2; i < 32; i++) hpush(8'(8'hA0 + i));
    hpush(8'hFF);
    check("R4", ovf_flag, 1, "overflow set");
    for (int i = 0; i < 29; i++) rpop();
    check("R7", irq, 0, "irq above 32-thr");
    rpop();
    check("R7", irq, 1, "irq at 2 left");
    rpop(); rpop();
    check("R9", terminate, 1, "terminate at empty tx");
    check("R4", ovf_flag, 1, "overflow sticky");

    // R11 streaming more than 32 bytes
    do_flush();
    hpush(8'h10); hpush(8'h11);
    for (int i = 0; i < 40; i++) begin
      host_wr = 1; host_wdata = 8'(8'h20 + i); radio_pop = 1; step();
      check("R11", fill_count, 2, "stream holds level");
    end
    host_wr = 0; radio_pop = 0;
    rpop(); rpop();
    step();

    // R8 polarity and new threshold in rx
    cfg_wr = 1; cfg_thresh = 5'd16; cfg_pol = 1; step(); cfg_wr = 0;
    mode_tx = 0; step();
    check("R8", irq, 1, "inverted idle level");
    for (int i = 0; i < 16; i++) rpush(8'(8'h40 + i));
    check("R8", irq, 0, "inverted active at 16");
    hpop();
    check("R8", irq, 1, "inverted release at 15");
    mode_tx = 1; step();
    check("R10", fill_count, 0, "direction change clears");
    repeat (3) step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule